// File: doc/BRIEF.md
# Shift-and-Add Squarer

This block returns the exact square of a 13-bit operand and uses no multiplier primitive. The operand goes through a conditional two's-complement fold that gives its magnitude. An unrolled array of shifted partial products, gated by the magnitude's own bits, is then summed in one combinational stage. The block targets fabrics where the dedicated multiply resources are reserved or absent, at a clock of 40 MHz or more.

A caller presents an operand, a signedness bit and a valid strobe. The block registers them at a clock edge. At the next edge it registers the 26-bit full-resolution square and raises the output strobe for one cycle. The operand can be read as unsigned, or as two's complement with its magnitude squared. The result is never negative, so the output is always unsigned. A new operand can be accepted on every cycle.

Top module: `sq_shiftadd`

## Requirements
- R1: With `signed_mode_i` = 0, the operand is read as an unsigned integer from 0 to 8191, and `square_o` is its exact 26-bit square.
- R2: With `signed_mode_i` = 1, the operand is read as two's complement (bit 12 is the sign), and `square_o` is the square of its magnitude. The code 0x1000 (-4096) gives 16777216.
- R3: `in_valid_i` is sampled high at clock edge N. `out_valid_o` is then high and `square_o` holds the result after edge N+1. `out_valid_o` is high for exactly one cycle per accepted operand, and operands on consecutive cycles give results on consecutive cycles.
- R4: When no operand was accepted at the previous edge, `square_o` keeps its last value and `out_valid_o` stays low, whatever the operand and mode inputs do.
- R5: A synchronous reset, `rst` high at a clock edge, clears `square_o` to 0 and `out_valid_o` to 0.
- R6: The mode bit is captured with its operand. A change of `signed_mode_i` or `operand_i` while `in_valid_i` is low does not alter the result of an operand already accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid_i | input | 1 | Operand strobe |
| operand_i | input | 13 | Operand to square |
| signed_mode_i | input | 1 | 0: unsigned operand, 1: two's-complement operand |
| out_valid_o | output | 1 | Result strobe, one cycle per accepted operand |
| square_o | output | 26 | Full-resolution square |

## Verification
The bench sweeps all 8192 codes in both modes. A wrong carry in the adder chain or a dropped partial product therefore shows up as a wrong square for some code.

The most negative code, -4096, is the edge case of the magnitude fold. A fold that sign-extends or saturates would return 16769025 or 0 instead of 16777216.

Between operands the bench flips the mode and scrambles the operand while the strobe is low. A design that samples the mode late would return the other mode's square. A design that reloads its result without a strobe would disturb the held value.

Back-to-back bursts and a reset in the middle of a run check the one-cycle strobe timing and the clearing of the result. A design off by a stage, or one that keeps a stale strobe, fails these checks.

// File: rtl/sqr_pkg.sv
package sqr_pkg;
    // Default operand width of the squarer.
    localparam int unsigned SQ_OPW = 13;

    // Interpretation of the operand.
    typedef enum logic {
        SQ_MODE_UNSIGNED = 1'b0,
        SQ_MODE_SIGNED   = 1'b1
    } sq_mode_e;
endpackage

// File: rtl/sqr_magnitude.sv
// Folds a two's-complement operand to its magnitude. For the most negative
// code, negation returns the same bit pattern, and that pattern read as
// unsigned is the correct magnitude, so no extra bit is needed.
module sqr_magnitude #(
    parameter int unsigned OP_W = sqr_pkg::SQ_OPW
) (
    input  logic [OP_W-1:0] op_i,
    input  logic            signed_mode_i,
    output logic [OP_W-1:0] mag_o
);
    localparam logic [OP_W-1:0] ONE = {{(OP_W-1){1'b0}}, 1'b1};

    logic negate;

    always_comb begin
        negate = (signed_mode_i == sqr_pkg::SQ_MODE_SIGNED) && op_i[OP_W-1];
        mag_o  = negate ? (~op_i + ONE) : op_i;
    end
endmodule

// File: rtl/sqr_ppsum.sv
// Unrolled shift-and-add: one gated, shifted copy of the magnitude per bit,
// accumulated through a chain of adders in a single combinational stage.
module sqr_ppsum #(
    parameter int unsigned OP_W = sqr_pkg::SQ_OPW,
    localparam int unsigned RES_W = 2 * OP_W
) (
    input  logic [OP_W-1:0]  mag_i,
    output logic [RES_W-1:0] sum_o
);
    logic [RES_W-1:0] mag_ext;
    assign mag_ext = {{OP_W{1'b0}}, mag_i};

    for (genvar i = 0; i < OP_W; i++) begin : g_row
        logic [RES_W-1:0] pp;
        logic [RES_W-1:0] acc;

        assign pp = mag_i[i] ? (mag_ext << i) : '0;

        if (i == 0) begin : g_first
            assign acc = pp;
        end else begin : g_next
            assign acc = g_row[i-1].acc + pp;
        end
    end

    assign sum_o = g_row[OP_W-1].acc;
endmodule

// File: rtl/sq_shiftadd.sv
module sq_shiftadd #(
    parameter int unsigned OP_W = sqr_pkg::SQ_OPW,
    localparam int unsigned RES_W = 2 * OP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid_i,
    input  logic [OP_W-1:0]  operand_i,
    input  logic             signed_mode_i,
    output logic             out_valid_o,
    output logic [RES_W-1:0] square_o
);
    localparam logic [RES_W-1:0] SIGNED_MAX_SQ = {{(RES_W-1){1'b0}}, 1'b1} << (RES_W - 2);

    typedef struct packed {
        logic             vld1;
        logic             mode1;
        logic [OP_W-1:0]  op1;
        logic             vld2;
        logic [RES_W-1:0] sq2;
    } state_t;

    state_t st_d, st_q;

    logic [OP_W-1:0]  mag;
    logic [RES_W-1:0] sum;

    sqr_magnitude #(.OP_W(OP_W)) u_mag (
        .op_i          (st_q.op1),
        .signed_mode_i (st_q.mode1),
        .mag_o         (mag)
    );

    sqr_ppsum #(.OP_W(OP_W)) u_sum (
        .mag_i (mag),
        .sum_o (sum)
    );

    always_comb begin
        st_d      = st_q;
        st_d.vld1 = in_valid_i;
        if (in_valid_i) begin
            st_d.op1   = operand_i;
            st_d.mode1 = signed_mode_i;
        end
        st_d.vld2 = st_q.vld1;
        if (st_q.vld1) begin
            st_d.sq2 = sum;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign out_valid_o = st_q.vld2;
    assign square_o    = st_q.sq2;

    // R5: reset clears result and strobe
    a_r5_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid_o && square_o == '0));

    // R3: an accepted operand reaches the output strobe one stage later
    a_r3_stage_one: assert property (@(posedge clk) disable iff (rst)
        in_valid_i |=> st_q.vld1);
    a_r3_stage_two: assert property (@(posedge clk) disable iff (rst)
        st_q.vld1 |=> out_valid_o);
    a_r3_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !st_q.vld1 |=> !out_valid_o);

    // R4: without an accepted operand the result holds
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        !st_q.vld1 |=> $stable(square_o));

    // R1: a square keeps the operand's parity and has bit 1 clear
    a_r1_parity: assert property (@(posedge clk) disable iff (rst)
        st_q.vld1 |=> (square_o[0] == $past(st_q.op1[0])));
    a_r1_bit1_zero: assert property (@(posedge clk) disable iff (rst)
        out_valid_o |-> !square_o[1]);

    // R2: a signed square never exceeds the square of the most negative code
    a_r2_signed_bound: assert property (@(posedge clk) disable iff (rst)
        (st_q.vld1 && st_q.mode1) |=> (square_o <= SIGNED_MAX_SQ));
endmodule

// File: tb/sq_shiftadd_test.sv
module sq_shiftadd_test;
    localparam int OP_W  = 13;
    localparam int RES_W = 26;
    localparam int NCODE = 1 << OP_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [OP_W-1:0]  operand = '0;
    logic             smode = 1'b0;
    logic             out_valid;
    logic [RES_W-1:0] square;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    sq_shiftadd #(.OP_W(OP_W)) uut (
        .clk           (clk),
        .rst           (rst),
        .in_valid_i    (in_valid),
        .operand_i     (operand),
        .signed_mode_i (smode),
        .out_valid_o   (out_valid),
        .square_o      (square)
    );

    function automatic longint ref_sq(input int code, input bit sgn);
        longint v;
        v = code;
        if (sgn && code >= NCODE / 2) v = code - NCODE;
        if (v < 0) v = -v;
        return v * v;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One operand; idle cycle with scrambled inputs; check at the result cycle.
    task automatic one_op(input int code, input bit sgn, input string req);
        longint e;
        e = ref_sq(code, sgn);
        @(negedge clk);
        in_valid = 1'b1; operand = OP_W'(code); smode = sgn;
        @(negedge clk);
        in_valid = 1'b0; operand = ~OP_W'(code); smode = ~sgn;  // R6 scramble
        @(negedge clk);
        check(out_valid == 1'b1 && longint'(square) == e, req, longint'(square), e);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R5: reset state
        check(out_valid == 1'b0, "R5 valid", out_valid, 0);
        check(square == '0, "R5 result", square, 0);
        rst = 1'b0;

        // R1: all unsigned codes
        for (int c = 0; c < NCODE; c++) one_op(c, 1'b0, "R1");
        // R2: all signed codes, including -4096 (code 0x1000)
        for (int c = 0; c < NCODE; c++) one_op(c, 1'b1, "R2");
        one_op(4096, 1'b1, "R2 most negative");
        check(square == 26'd16777216, "R2 most negative literal", square, 16777216);

        // R6: signed -1 accepted, mode flipped afterwards, result stays 1
        one_op(8191, 1'b1, "R6");
        check(square == 26'd1, "R6 mode captured", square, 1);

        // R4: idle cycles with changing inputs keep the result, strobe low
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            operand = OP_W'(k * 977); smode = k[0];
            check(out_valid == 1'b0, "R4 strobe low", out_valid, 0);
            check(square == 26'd1, "R4 hold", square, 1);
        end

        // R3: back-to-back burst, results on consecutive cycles
        begin
            int ops[12];
            for (int j = 0; j < 12; j++) ops[j] = 8191 - 37 * j;
            for (int j = 0; j < 14; j++) begin
                @(negedge clk);
                if (j >= 2) check(out_valid == 1'b1 && longint'(square) == ref_sq(ops[j-2], 1'b0),
                                  "R3 burst", longint'(square), ref_sq(ops[j-2], 1'b0));
                if (j < 12) begin
                    in_valid = 1'b1; operand = OP_W'(ops[j]); smode = 1'b0;
                end else begin
                    in_valid = 1'b0;
                end
            end
            @(negedge clk);
            check(out_valid == 1'b0, "R3 strobe drops", out_valid, 0);
        end

        // R5: reset in mid-run clears a held result
        one_op(5000, 1'b0, "R1 pre-reset");
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check(out_valid == 1'b0, "R5 mid-run valid", out_valid, 0);
        check(square == '0, "R5 mid-run result", square, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (120000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule